// File: doc/BRIEF.md
# Pipeline Hazard Stall and Flush Controller

This block makes the hazard decisions for an in-order integer pipeline with five stages: fetch, decode, execute, memory and write-back. Each cycle it compares the source registers of the instruction in decode with the destination registers of the two older instructions in execute and memory. It also checks whether a conditional branch that has reached execute was taken. From these it drives the program-counter write enable, a hold and a clear for the fetch/decode register, and bubble insertion into the decode/execute register. A small model of the stage registers is built in. It carries a tag for each instruction to write-back, so the decisions can be seen at the ports.

A mode input selects the dependency policy. With forwarding off, a consumer waits in decode until its producer has reached write-back. The register file is taken to write before it reads within a cycle, so the consumer may read in the same cycle the producer writes back. With forwarding on, only a load followed at once by a user of the loaded register is held, and for one cycle only. Fetch assumes branches are not taken. A branch that turns out taken in execute discards the two younger instructions and steers the program counter to the target.

Top module: `hazard_ctrl`

## Requirements
- R1: While reset is asserted and before the first clock edge after its release, the program counter is 0, `pc_we` is 1, and the execute and write-back stages are empty (`ex_valid` = 0, `wb_valid` = 0).
- R2: In a stall cycle, `pc_we` is 0, `ifid_hold` is 1 and `idex_bubble` is 1, all in the same cycle. The fetch/decode register keeps its instruction. Instructions already in execute, memory and write-back keep moving, so a producer fetched at index i still reaches write-back on cycle i+4.
- R3: With `fwd_en` = 0, let d be how many instructions separate the consumer from the nearest older producer of one of its used sources. The consumer is stalled for 2 cycles when d = 1, 1 cycle when d = 2, and 0 cycles when d ≥ 3. This holds whether or not the producer is a load, and whichever source slot holds the register.
- R4: With `fwd_en` = 1, the only stall is a load (`if_mem_rd` = 1 with `if_reg_we` = 1) followed at once (d = 1) by a user of its destination. That case costs exactly 1 cycle. A non-load producer, or a load with d ≥ 2, causes no stall.
- R5: None of the following ever causes a stall: a source that is register 0, a producer whose register-write enable is 0, or a matching register in a source slot whose use flag is 0.
- R6: A valid branch in execute with `ex_br_taken` = 1 sets `ifid_clear` and `idex_bubble` in that cycle. The program counter holds `ex_br_target` after the next edge. The two instructions after the branch never reach write-back, and the target instruction reaches write-back 7 cycles after the branch was fetched.
- R7: A branch in execute with `ex_br_taken` = 0 causes no clear and no bubble. The next sequential instruction reaches write-back one cycle after the branch does.
- R8: When a stall condition and a taken branch fall in the same cycle, the flush wins: `ifid_hold` = 0, `pc_we` = 1, `ifid_clear` = 1.
- R9: A bubble clears the register-write, memory-read, memory-write, branch and valid bits. Whenever `wb_valid` = 0, `wb_reg_we` is also 0.
- R10: Instructions that are not flushed reach write-back exactly once and in strictly increasing tag order, where the tag is the fetch address. A held instruction is never duplicated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fwd_en | input | 1 | 1 = forwarding paths present (load-use stall only) |
| if_rs1 | input | 5 | First source register of the fetched instruction |
| if_rs2 | input | 5 | Second source register of the fetched instruction |
| if_rd | input | 5 | Destination register of the fetched instruction |
| if_use1 | input | 1 | First source is read |
| if_use2 | input | 1 | Second source is read |
| if_reg_we | input | 1 | Instruction writes `if_rd` |
| if_mem_rd | input | 1 | Instruction is a load |
| if_mem_wr | input | 1 | Instruction is a store |
| if_branch | input | 1 | Instruction is a conditional branch |
| ex_br_taken | input | 1 | Outcome of the branch now in execute |
| ex_br_target | input | PC_W | Target of the branch now in execute |
| pc | output | PC_W | Fetch address |
| pc_we | output | 1 | Program counter advances or is redirected |
| ifid_hold | output | 1 | Fetch/decode register keeps its contents |
| ifid_clear | output | 1 | Fetch/decode register loads a bubble |
| idex_bubble | output | 1 | Decode/execute register loads a bubble |
| ex_valid | output | 1 | A real instruction is in execute |
| ex_tag | output | 8 | Tag of the instruction in execute |
| wb_valid | output | 1 | A real instruction is in write-back |
| wb_tag | output | 8 | Tag of the instruction in write-back |
| wb_rd | output | 5 | Destination register in write-back |
| wb_reg_we | output | 1 | Register write enable in write-back |

## Verification
The control outputs `pc_we`, `ifid_hold`, `ifid_clear` and `idex_bubble` are combinational from the stage registers. The bench therefore samples them on the falling edge of the same cycle in which the hazard is present. An instruction fetched at index i reaches write-back on the falling edge after rising edge i+4, plus one cycle for each stall. A taken branch adds a shift of 3 between the branch index and the arrival of its target. The bench counts rising edges from reset release and compares the first write-back cycle of each watched tag against these formulas, sweeping mode, producer kind, distance and source slot.

// File: rtl/hz_pkg.sv
package hz_pkg;
  localparam int RA_W  = 5;
  localparam int TAG_W = 8;
  localparam int NSRC  = 2;

  typedef struct packed {
    logic             valid;
    logic             reg_we;
    logic             mem_rd;
    logic             mem_wr;
    logic             branch;
    logic             use1;
    logic             use2;
    logic [RA_W-1:0]  rs1;
    logic [RA_W-1:0]  rs2;
    logic [RA_W-1:0]  rd;
    logic [TAG_W-1:0] tag;
  } stage_t;

  function automatic stage_t make_bubble(input stage_t s);
    stage_t b;
    b        = s;
    b.valid  = 1'b0;
    b.reg_we = 1'b0;
    b.mem_rd = 1'b0;
    b.mem_wr = 1'b0;
    b.branch = 1'b0;
    b.use1   = 1'b0;
    b.use2   = 1'b0;
    return b;
  endfunction
endpackage

// File: rtl/hz_dep_match.sv
module hz_dep_match
  import hz_pkg::*;
(
  input  logic [RA_W-1:0] src,
  input  logic            src_use,
  input  logic            prod_valid,
  input  logic            prod_we,
  input  logic [RA_W-1:0] prod_rd,
  output logic            hit
);
  logic src_nonzero;

  always_comb begin
    src_nonzero = |src;
    hit = src_use && src_nonzero && prod_valid && prod_we && (src == prod_rd);
  end
endmodule

// File: rtl/hz_hazard_unit.sv
module hz_hazard_unit
  import hz_pkg::*;
(
  input  logic   fwd_en,
  input  stage_t ifid,
  input  stage_t idex,
  input  stage_t exmem,
  input  logic   ex_br_taken,
  output logic   pc_we,
  output logic   ifid_hold,
  output logic   ifid_clear,
  output logic   idex_bubble,
  output logic   redirect
);
  logic [RA_W-1:0] src_a [NSRC];
  logic            use_a [NSRC];
  logic [NSRC-1:0] hit_ex;
  logic [NSRC-1:0] hit_mem;
  logic            raw_ex, raw_mem, load_use, stall_req, flush, stall;

  always_comb begin
    src_a[0] = ifid.rs1;
    src_a[1] = ifid.rs2;
    use_a[0] = ifid.use1;
    use_a[1] = ifid.use2;
  end

  for (genvar s = 0; s < NSRC; s++) begin : g_src
    hz_dep_match u_ex (
      .src        (src_a[s]),
      .src_use    (use_a[s]),
      .prod_valid (idex.valid),
      .prod_we    (idex.reg_we),
      .prod_rd    (idex.rd),
      .hit        (hit_ex[s])
    );
    hz_dep_match u_mem (
      .src        (src_a[s]),
      .src_use    (use_a[s]),
      .prod_valid (exmem.valid),
      .prod_we    (exmem.reg_we),
      .prod_rd    (exmem.rd),
      .hit        (hit_mem[s])
    );
  end

  always_comb begin
    raw_ex    = |hit_ex;
    raw_mem   = |hit_mem;
    load_use  = raw_ex && idex.mem_rd;
    stall_req = ifid.valid && (fwd_en ? load_use : (raw_ex || raw_mem));
    flush     = idex.valid && idex.branch && ex_br_taken;
    stall     = stall_req && !flush;
    pc_we       = !stall;
    ifid_hold   = stall;
    ifid_clear  = flush;
    idex_bubble = stall || flush;
    redirect    = flush;
  end
endmodule

// File: rtl/hz_pipe_regs.sv
module hz_pipe_regs
  import hz_pkg::*;
#(
  parameter int PC_W = 8
)(
  input  logic            clk,
  input  logic            rst_n,
  input  stage_t          fetch,
  input  logic            pc_we,
  input  logic            ifid_hold,
  input  logic            ifid_clear,
  input  logic            idex_bubble,
  input  logic            redirect,
  input  logic [PC_W-1:0] target,
  output logic [PC_W-1:0] pc,
  output stage_t          ifid,
  output stage_t          idex,
  output stage_t          exmem,
  output stage_t          memwb
);
  localparam stage_t EMPTY = '0;

  logic [PC_W-1:0] pc_nxt;
  stage_t          ifid_nxt, idex_nxt;
  logic            ifid_en;

  always_comb begin
    pc_nxt   = redirect ? target : pc + PC_W'(1);
    ifid_en  = !ifid_hold;
    ifid_nxt = ifid_clear ? make_bubble(fetch) : fetch;
    idex_nxt = idex_bubble ? make_bubble(ifid) : ifid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc    <= '0;
      ifid  <= EMPTY;
      idex  <= EMPTY;
      exmem <= EMPTY;
      memwb <= EMPTY;
    end else begin
      if (pc_we)   pc   <= pc_nxt;
      if (ifid_en) ifid <= ifid_nxt;
      idex  <= idex_nxt;
      exmem <= idex;
      memwb <= exmem;
    end
  end
endmodule

// File: rtl/hazard_ctrl.sv
module hazard_ctrl
  import hz_pkg::*;
#(
  parameter int PC_W = 8
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fwd_en,
  input  logic [4:0]       if_rs1,
  input  logic [4:0]       if_rs2,
  input  logic [4:0]       if_rd,
  input  logic             if_use1,
  input  logic             if_use2,
  input  logic             if_reg_we,
  input  logic             if_mem_rd,
  input  logic             if_mem_wr,
  input  logic             if_branch,
  input  logic             ex_br_taken,
  input  logic [PC_W-1:0]  ex_br_target,
  output logic [PC_W-1:0]  pc,
  output logic             pc_we,
  output logic             ifid_hold,
  output logic             ifid_clear,
  output logic             idex_bubble,
  output logic             ex_valid,
  output logic [7:0]       ex_tag,
  output logic             wb_valid,
  output logic [7:0]       wb_tag,
  output logic [4:0]       wb_rd,
  output logic             wb_reg_we
);
  stage_t fetch_s, ifid_q, idex_q, exmem_q, memwb_q;
  logic   redirect;

  always_comb begin
    fetch_s        = '0;
    fetch_s.valid  = 1'b1;
    fetch_s.reg_we = if_reg_we;
    fetch_s.mem_rd = if_mem_rd;
    fetch_s.mem_wr = if_mem_wr;
    fetch_s.branch = if_branch;
    fetch_s.use1   = if_use1;
    fetch_s.use2   = if_use2;
    fetch_s.rs1    = if_rs1;
    fetch_s.rs2    = if_rs2;
    fetch_s.rd     = if_rd;
    fetch_s.tag    = TAG_W'(pc);
  end

  hz_hazard_unit u_haz (
    .fwd_en      (fwd_en),
    .ifid        (ifid_q),
    .idex        (idex_q),
    .exmem       (exmem_q),
    .ex_br_taken (ex_br_taken),
    .pc_we       (pc_we),
    .ifid_hold   (ifid_hold),
    .ifid_clear  (ifid_clear),
    .idex_bubble (idex_bubble),
    .redirect    (redirect)
  );

  hz_pipe_regs #(.PC_W(PC_W)) u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .fetch       (fetch_s),
    .pc_we       (pc_we),
    .ifid_hold   (ifid_hold),
    .ifid_clear  (ifid_clear),
    .idex_bubble (idex_bubble),
    .redirect    (redirect),
    .target      (ex_br_target),
    .pc          (pc),
    .ifid        (ifid_q),
    .idex        (idex_q),
    .exmem       (exmem_q),
    .memwb       (memwb_q)
  );

  always_comb begin
    ex_valid  = idex_q.valid;
    ex_tag    = idex_q.tag;
    wb_valid  = memwb_q.valid;
    wb_tag    = memwb_q.tag;
    wb_rd     = memwb_q.rd;
    wb_reg_we = memwb_q.reg_we;
  end
endmodule

// File: rtl/hazard_ctrl_chk.sv
module hazard_ctrl_chk #(
  parameter int PC_W = 8
)(
  input logic            clk,
  input logic            rst_n,
  input logic            fwd_en,
  input logic [PC_W-1:0] pc,
  input logic            pc_we,
  input logic            ifid_hold,
  input logic            ifid_clear,
  input logic            idex_bubble,
  input logic [PC_W-1:0] ex_br_target,
  input logic            wb_valid,
  input logic            wb_reg_we,
  input logic [7:0]      ifid_tag,
  input logic            idex_mem_rd
);
  // R2: a stall freezes fetch and injects a bubble
  a_r2_stall_freezes_pc: assert property (@(posedge clk) disable iff (!rst_n)
    ifid_hold |-> (!pc_we && idex_bubble));

  // R2 / R10: the held decode instruction is unchanged next cycle
  a_r2_hold_keeps_ifid: assert property (@(posedge clk) disable iff (!rst_n)
    ifid_hold |=> $stable(ifid_tag));

  // R8: a flush never coexists with a hold
  a_r8_flush_wins: assert property (@(posedge clk) disable iff (!rst_n)
    ifid_clear |-> (!ifid_hold && pc_we && idex_bubble));

  // R6: fetch is redirected to the branch target after a flush
  a_r6_redirect_target: assert property (@(posedge clk) disable iff (!rst_n)
    ifid_clear |=> (pc == $past(ex_br_target)));

  // R4: with forwarding, only a load in execute can cause a stall
  a_r4_load_use_only: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd_en && ifid_hold) |-> idex_mem_rd);

  // R9: a bubble in write-back never writes a register
  a_r9_bubble_clean: assert property (@(posedge clk) disable iff (!rst_n)
    !wb_valid |-> !wb_reg_we);
endmodule

bind hazard_ctrl hazard_ctrl_chk #(.PC_W(PC_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .fwd_en       (fwd_en),
  .pc           (pc),
  .pc_we        (pc_we),
  .ifid_hold    (ifid_hold),
  .ifid_clear   (ifid_clear),
  .idex_bubble  (idex_bubble),
  .ex_br_target (ex_br_target),
  .wb_valid     (wb_valid),
  .wb_reg_we    (wb_reg_we),
  .ifid_tag     (ifid_q.tag),
  .idex_mem_rd  (idex_q.mem_rd)
);

// File: tb/hazard_ctrl_tb.sv
module hazard_ctrl_tb;
  import hz_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int PC_W       = 8;
  localparam int PROG_N     = 64;
  localparam int RUN_CYC    = 30;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            fwd_en = 1'b0;
  logic [4:0]      if_rs1, if_rs2, if_rd;
  logic            if_use1, if_use2, if_reg_we, if_mem_rd, if_mem_wr, if_branch;
  logic            ex_br_taken;
  logic [PC_W-1:0] ex_br_target;
  logic [PC_W-1:0] pc;
  logic            pc_we, ifid_hold, ifid_clear, idex_bubble;
  logic            ex_valid, wb_valid, wb_reg_we;
  logic [7:0]      ex_tag, wb_tag;
  logic [4:0]      wb_rd;

  stage_t          prog  [PROG_N];
  logic            taken [PROG_N];
  logic [PC_W-1:0] tgt   [PROG_N];

  int checks = 0;
  int fails  = 0;
  int wd     = 0;

  // results of the last run
  int first_wb [PROG_N];
  int bubbles, clears, order_bad, handshake_bad, clean_bad;

  always #(CLK_PERIOD/2) clk = ~clk;

  always_comb begin
    stage_t s;
    s = prog[pc[5:0]];
    if_rs1    = s.rs1;
    if_rs2    = s.rs2;
    if_rd     = s.rd;
    if_use1   = s.use1;
    if_use2   = s.use2;
    if_reg_we = s.reg_we;
    if_mem_rd = s.mem_rd;
    if_mem_wr = s.mem_wr;
    if_branch = s.branch;
    ex_br_taken  = ex_valid && taken[ex_tag[5:0]];
    ex_br_target = tgt[ex_tag[5:0]];
  end

  hazard_ctrl #(.PC_W(PC_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .fwd_en(fwd_en),
    .if_rs1(if_rs1), .if_rs2(if_rs2), .if_rd(if_rd),
    .if_use1(if_use1), .if_use2(if_use2), .if_reg_we(if_reg_we),
    .if_mem_rd(if_mem_rd), .if_mem_wr(if_mem_wr), .if_branch(if_branch),
    .ex_br_taken(ex_br_taken), .ex_br_target(ex_br_target),
    .pc(pc), .pc_we(pc_we), .ifid_hold(ifid_hold), .ifid_clear(ifid_clear),
    .idex_bubble(idex_bubble), .ex_valid(ex_valid), .ex_tag(ex_tag),
    .wb_valid(wb_valid), .wb_tag(wb_tag), .wb_rd(wb_rd), .wb_reg_we(wb_reg_we)
  );

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  always @(posedge clk) begin
    wd++;
    if (wd > 100000) begin
      fails++;
      $display("FAIL R10 watchdog expired: actual %0d cycles, expected < 100000", wd);
      summary();
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic clear_prog();
    for (int i = 0; i < PROG_N; i++) begin
      prog[i]       = '0;
      prog[i].valid = 1'b1;
      prog[i].rd    = 5'd20 + 5'(i % 8);
      taken[i]      = 1'b0;
      tgt[i]        = '0;
    end
  endtask

  task automatic set_prod(input int i, input logic [4:0] rd, input logic we, input logic ld);
    prog[i].rd     = rd;
    prog[i].reg_we = we;
    prog[i].mem_rd = ld;
  endtask

  task automatic set_cons(input int i, input logic [4:0] r, input int slot, input logic u);
    if (slot == 0) begin prog[i].rs1 = r; prog[i].use1 = u; end
    else           begin prog[i].rs2 = r; prog[i].use2 = u; end
  endtask

  // reset, check R1, then run RUN_CYC edges recording observations
  task automatic run_prog(input logic fwd);
    int last;
    fwd_en = fwd;
    rst_n  = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(pc == 0 && pc_we && !ex_valid && !wb_valid, "R1 reset state", {pc_we, ex_valid, wb_valid}, 3'b100);
    for (int i = 0; i < PROG_N; i++) first_wb[i] = -1;
    bubbles = 0; clears = 0; order_bad = 0; handshake_bad = 0; clean_bad = 0;
    last = -1;
    for (int c = 1; c <= RUN_CYC; c++) begin
      @(posedge clk);
      @(negedge clk);
      if (idex_bubble) bubbles++;
      if (ifid_clear) clears++;
      if (ifid_hold && (pc_we || !idex_bubble)) handshake_bad++;
      if (!wb_valid && wb_reg_we) clean_bad++;
      if (wb_valid) begin
        if (int'(wb_tag) <= last) order_bad++;
        last = int'(wb_tag);
        if (first_wb[wb_tag[5:0]] < 0) first_wb[wb_tag[5:0]] = c;
      end
    end
  endtask

  initial begin
    clear_prog();

    // R3 / R4 sweep: mode x producer kind x distance x source slot
    for (int fw = 0; fw < 2; fw++)
      for (int ld = 0; ld < 2; ld++)
        for (int d = 1; d <= 3; d++)
          for (int sl = 0; sl < 2; sl++) begin
            int exp_st;
            clear_prog();
            set_prod(0, 5'd5, 1'b1, 1'(ld));
            set_cons(d, 5'd5, sl, 1'b1);
            run_prog(1'(fw));
            if (fw == 1) exp_st = (ld == 1 && d == 1) ? 1 : 0;
            else         exp_st = (d == 1) ? 2 : (d == 2) ? 1 : 0;
            if (fw == 1) chk(first_wb[d] == d + 4 + exp_st, "R4 consumer write-back cycle", first_wb[d], d + 4 + exp_st);
            else         chk(first_wb[d] == d + 4 + exp_st, "R3 consumer write-back cycle", first_wb[d], d + 4 + exp_st);
            chk(bubbles == exp_st, "R3/R4 bubble count", bubbles, exp_st);
            chk(first_wb[0] == 4, "R2 producer keeps advancing", first_wb[0], 4);
            chk(handshake_bad == 0, "R2 stall handshake", handshake_bad, 0);
            chk(order_bad == 0, "R10 in-order single write-back", order_bad, 0);
            chk(clean_bad == 0, "R9 bubble has no write", clean_bad, 0);
          end

    // R3 both sources on the same producer still costs 2 cycles
    clear_prog();
    set_prod(0, 5'd9, 1'b1, 1'b0);
    set_cons(1, 5'd9, 0, 1'b1);
    set_cons(1, 5'd9, 1, 1'b1);
    run_prog(1'b0);
    chk(first_wb[1] == 7, "R3 two sources one producer", first_wb[1], 7);

    // R5 register 0 is never a dependency
    clear_prog();
    set_prod(0, 5'd0, 1'b1, 1'b1);
    set_cons(1, 5'd0, 0, 1'b1);
    run_prog(1'b0);
    chk(bubbles == 0 && first_wb[1] == 5, "R5 register zero ignored", first_wb[1], 5);

    // R5 producer without register write is ignored
    clear_prog();
    set_prod(0, 5'd6, 1'b0, 1'b0);
    prog[0].mem_wr = 1'b1;
    set_cons(1, 5'd6, 1, 1'b1);
    run_prog(1'b0);
    chk(bubbles == 0 && first_wb[1] == 5, "R5 non-writing producer ignored", first_wb[1], 5);

    // R5 unused source slot is ignored
    clear_prog();
    set_prod(0, 5'd7, 1'b1, 1'b1);
    set_cons(1, 5'd7, 0, 1'b0);
    run_prog(1'b1);
    chk(bubbles == 0 && first_wb[1] == 5, "R5 unused source ignored", first_wb[1], 5);

    // R6 taken branch at 2 to 10
    clear_prog();
    prog[2].branch = 1'b1;
    taken[2] = 1'b1;
    tgt[2]   = 8'd10;
    run_prog(1'b1);
    chk(first_wb[10] == 9, "R6 target write-back cycle", first_wb[10], 9);
    chk(first_wb[3] < 0 && first_wb[4] < 0, "R6 younger instructions discarded", first_wb[3] + first_wb[4], -2);
    chk(clears == 1 && bubbles == 1, "R6 one clear and bubble", clears * 10 + bubbles, 11);
    chk(order_bad == 0, "R10 order across branch", order_bad, 0);

    // R7 not-taken branch
    clear_prog();
    prog[2].branch = 1'b1;
    run_prog(1'b1);
    chk(clears == 0 && bubbles == 0, "R7 no flush when not taken", clears + bubbles, 0);
    chk(first_wb[3] == first_wb[2] + 1, "R7 sequential follow-on", first_wb[3], first_wb[2] + 1);

    // R8 stall and flush in the same cycle: flush wins
    clear_prog();
    set_prod(1, 5'd7, 1'b1, 1'b0);
    prog[2].branch = 1'b1;
    taken[2] = 1'b1;
    tgt[2]   = 8'd10;
    set_cons(3, 5'd7, 0, 1'b1);
    fwd_en = 1'b0;
    rst_n  = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    for (int c = 1; c <= 4; c++) begin
      @(posedge clk);
      @(negedge clk);
    end
    chk(ifid_clear && !ifid_hold && pc_we && idex_bubble, "R8 flush over stall",
        {ifid_clear, ifid_hold, pc_we, idex_bubble}, 4'b1011);
    run_prog(1'b0);
    chk(first_wb[10] == 9 && first_wb[3] < 0, "R8 target reached after flush", first_wb[10], 9);

    summary();
    $finish;
  end
endmodule